// File: doc/BRIEF.md
# Register-Driven I2C Bus Master

This block is a single-master I2C controller that software drives through a byte-wide register port. Software queues an address byte (seven address bits above a read/write bit) in a small transmit FIFO. It then raises the master-mode bit in the control register to put a START on the bus. Each later write to the transmit data register queues another byte for the bus. Dropping master mode makes the controller finish the byte in flight and then close with a STOP. When the bus has returned to idle, a latched bus-idle flag reports it.

Received bytes go into a receive FIFO. Once the FIFO holds more bytes than a programmable, zero-based threshold, the controller holds SCL low and stalls the bus until software drains the FIFO. While the bus is stalled, software can change the acknowledge choice for the next byte or drop master mode. Status bits latch and are cleared by writing 1 to them. An acknowledge fault or a lost arbitration is reported there. SCL and SDA are open-drain: the block drives pull-low enables and samples both lines.

Top module: `i2c_reg_master`

## Requirements
- R1: After reset, both pull-low enables are 0 and the control register reads 0x00. The status register reads 0x02: only transmit-empty is set, because the transmit FIFO is empty.
- R2: The first byte popped from the transmit FIFO after START is the address byte. Bits 7:1 carry the slave address and bit 0 the direction (1 read, 0 write). The bus carries it MSB first.
- R3: A rising edge of control bit 1 (master mode) while control bit 0 (enable) is set and the transmit FIFO is non-empty starts a transfer: SDA falls while SCL is high. Outside START and STOP, SDA changes only while SCL is low.
- R4: With master mode cleared, the controller generates a STOP (SDA rises while SCL is high) after the byte in progress. On finishing the STOP it sets status bit 4 (bus idle).
- R5: During a read, each received byte is answered with ACK when control bit 3 is 0 and with NACK when it is 1. The bit is sampled at that byte's acknowledge slot.
- R6: While the receive FIFO holds more bytes than the threshold, SCL is held low and no further byte is clocked.
- R7: The threshold register (offset 4) is zero-based. Status bit 0 (receive full) asserts when the FIFO count exceeds the threshold, so a value of 1 asserts it after two bytes. The receive FIFO never overflows.
- R8: Writing 1 to a status bit (offset 1) clears it. Transmit-empty (bit 1) stays cleared only if the transmit FIFO holds data at the time of the write.
- R9: A NACK on any byte the controller sends sets status bit 2 (transmit error), and the controller then issues a STOP.
- R10: If SDA reads low at a sample point while the controller is sending a 1, it sets status bit 3 (arbitration lost), releases both lines and clears master mode.
- R11: Clearing the enable bit returns the controller to idle and releases both lines. A write that turns enable from 1 to 0 flushes both FIFOs, and no START follows until a new address is queued.
- R12: In write mode, queued data bytes go out in order. Transmit-empty sets once the FIFO has drained onto the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register offset: 0 control, 1 status, 2 transmit data, 3 receive data, 4 threshold |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a read at offset 3 pops the receive FIFO |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| scl_i | input | 1 | Sampled SCL line |
| scl_oe | output | 1 | Pulls SCL low when 1 |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Pulls SDA low when 1 |

## Verification
Assertions check on every cycle that SDA moves only while SCL is low except in START and STOP, and that a receive FIFO above threshold keeps SCL low. They also check that the receive FIFO is never pushed when full, that a disabled controller lets go of both lines, and that arbitration loss leaves master mode cleared with the bus released. Only the bench scenarios can show the end-to-end effects. These are the address and data bytes a slave model sees in order, and the ACK/NACK pattern it receives. They also include the zero-based threshold counting, the transmit-empty clear rule, the STOP after an address NACK, and the FIFO flush on disable.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE, ST_START, ST_XFER, ST_HOLD, ST_STOP
    } bus_st_e;

    localparam logic [2:0] A_CTRL = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_TXD  = 3'd2;
    localparam logic [2:0] A_RXD  = 3'd3;
    localparam logic [2:0] A_THR  = 3'd4;

    localparam int C_EN   = 0;
    localparam int C_MS   = 1;
    localparam int C_TX   = 2;
    localparam int C_NACK = 3;

    localparam int S_RXF   = 0;
    localparam int S_TXE   = 1;
    localparam int S_TXERR = 2;
    localparam int S_ARB   = 3;
    localparam int S_IDLE  = 4;
    localparam int SW      = 5;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int DIV = 8,
    localparam int DW = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    logic [DW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == DW'(DIV - 1));

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      count
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [AW:0]   cnt;
    } fifo_st_t;

    fifo_st_t d, q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    assign do_push = push && (q.cnt != (AW+1)'(DEPTH));
    assign do_pop  = pop && (q.cnt != '0);
    assign dout    = mem[q.rp];
    assign count   = q.cnt;

    always_comb begin
        d = q;
        if (do_push) d.wp = q.wp + 1'b1;
        if (do_pop)  d.rp = q.rp + 1'b1;
        d.cnt = q.cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        if (flush) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[q.wp] <= din;
    end
endmodule

// File: rtl/i2c_reg_master.sv
module i2c_reg_master
    import i2cm_pkg::*;
#(
    parameter int DIV        = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       scl_i,
    output logic       scl_oe,
    input  logic       sda_i,
    output logic       sda_oe
);
    localparam int TW = $clog2(FIFO_DEPTH);
    localparam int CW = TW + 1;

    typedef struct packed {
        bus_st_e       st;
        logic [1:0]    ph;
        logic [3:0]    bitn;
        logic [7:0]    sh;
        logic          smp;
        logic          sending;
        logic          addr_byte;
        logic          rd_mode;
        logic          en, ms, dir_tx, nack, ms_prev;
        logic [SW-1:0] stat;
        logic [TW-1:0] thr;
    } mst_t;

    mst_t d, q;
    logic tick, adv, rx_over, tx_pop, rx_push, flush;
    logic wr_ctrl, wr_stat, wr_thr, tx_push, rx_pop;
    logic [7:0] tx_dout, rx_dout;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic [SW-1:0] stat_set;

    i2cm_tick #(.DIV(DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(q.st != ST_IDLE), .tick(tick));

    i2cm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(tx_push), .din(reg_wdata),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt));

    i2cm_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush), .push(rx_push), .din(q.sh),
        .pop(rx_pop), .dout(rx_dout), .count(rx_cnt));

    assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_thr  = reg_wr && (reg_addr == A_THR);
    assign tx_push = reg_wr && (reg_addr == A_TXD);
    assign rx_pop  = reg_rd && (reg_addr == A_RXD);
    assign rx_over = rx_cnt > CW'(q.thr);

    // Bus drive per state and quarter-bit phase
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (q.st)
            ST_START: sda_oe = q.ph[1];
            ST_XFER: begin
                scl_oe = !q.ph[1];
                if (q.bitn < 4'd8) sda_oe = q.sending && !q.sh[7];
                else               sda_oe = !q.sending && !q.nack;
            end
            ST_HOLD:  scl_oe = 1'b1;
            ST_STOP: begin
                scl_oe = (q.ph == 2'd0);
                sda_oe = !q.ph[1];
            end
            default: ;
        endcase
    end

    // A tick only advances once a released SCL is seen high (slave stretch)
    assign adv = tick && (scl_oe || scl_i);

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        flush    = 1'b0;
        stat_set = '0;
        d.ms_prev = q.ms;
        if (wr_ctrl) begin
            d.en     = reg_wdata[C_EN];
            d.ms     = reg_wdata[C_MS];
            d.dir_tx = reg_wdata[C_TX];
            d.nack   = reg_wdata[C_NACK];
            flush    = q.en && !reg_wdata[C_EN];
        end
        if (wr_thr) d.thr = reg_wdata[TW-1:0];

        unique case (q.st)
            ST_IDLE: begin
                if (q.en && q.ms && !q.ms_prev && tx_cnt != '0) begin
                    tx_pop      = 1'b1;
                    d.sh        = tx_dout;
                    d.rd_mode   = tx_dout[0];
                    d.addr_byte = 1'b1;
                    d.sending   = 1'b1;
                    d.ph        = '0;
                    d.bitn      = '0;
                    d.st        = ST_START;
                end
            end
            ST_START, ST_STOP: begin
                if (adv) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd3) begin
                        d.st = (q.st == ST_START) ? ST_XFER : ST_IDLE;
                        stat_set[S_IDLE] = (q.st == ST_STOP);
                    end
                end
            end
            ST_XFER: begin
                if (adv) begin
                    d.ph = q.ph + 2'd1;
                    if (q.ph == 2'd2) begin
                        d.smp = sda_i;
                        if (q.bitn < 4'd8 && q.sending && q.sh[7] && !sda_i) begin
                            d.st = ST_IDLE;
                            d.ms = 1'b0;
                            stat_set[S_ARB] = 1'b1;
                        end
                    end
                    if (q.ph == 2'd3) begin
                        d.bitn = q.bitn + 4'd1;
                        if (q.bitn < 4'd8) begin
                            d.sh = {q.sh[6:0], q.smp};
                        end else begin
                            d.bitn = '0;
                            d.addr_byte = 1'b0;
                            if (!q.sending) begin
                                rx_push = 1'b1;
                                d.st    = ST_HOLD;
                            end else if (q.smp) begin
                                stat_set[S_TXERR] = 1'b1;
                                d.st = ST_STOP;
                            end else if (q.addr_byte && q.rd_mode) begin
                                d.sending = 1'b0;
                            end else begin
                                d.st = ST_HOLD;
                            end
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    d.ph   = '0;
                    d.bitn = '0;
                    if (q.rd_mode) begin
                        if (!rx_over) begin
                            d.st      = q.ms ? ST_XFER : ST_STOP;
                            d.sending = 1'b0;
                        end
                    end else if (tx_cnt != '0) begin
                        tx_pop    = 1'b1;
                        d.sh      = tx_dout;
                        d.sending = 1'b1;
                        d.st      = ST_XFER;
                    end else if (!q.ms) begin
                        d.st = ST_STOP;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (!q.en) d.st = ST_IDLE;

        d.stat = (q.stat & ~(wr_stat ? reg_wdata[SW-1:0] : '0)) | stat_set;
        d.stat[S_RXF] = d.stat[S_RXF] | rx_over;
        d.stat[S_TXE] = d.stat[S_TXE] | (tx_cnt == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {4'b0, q.nack, q.dir_tx, q.ms, q.en};
            A_STAT:  reg_rdata = {3'b0, q.stat};
            A_RXD:   reg_rdata = rx_dout;
            A_THR:   reg_rdata = 8'(q.thr);
            default: reg_rdata = 8'h00;
        endcase
    end

    // R3: SDA moves while SCL is released only to form START/STOP (or on release)
    p_sda_moves_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && sda_oe != $past(sda_oe))
            |-> (q.st == ST_START || q.st == ST_STOP || q.st == ST_IDLE));

    // R6: receive FIFO above threshold keeps SCL pulled low during a transfer
    p_stall_scl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.rd_mode && rx_over && q.en && (q.st == ST_HOLD || q.st == ST_XFER)) |-> scl_oe);

    // R7: no push into a full receive FIFO
    p_no_rx_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> (rx_cnt != CW'(FIFO_DEPTH)));

    // R10: arbitration loss leaves master mode off and the bus released
    p_arb_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.stat[S_ARB]) |-> (!q.ms && !scl_oe && !sda_oe));

    // R11: a disabled controller drives neither line on the next cycle
    p_disable_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !q.en |=> (!scl_oe && !sda_oe));
endmodule

// File: tb/tb_i2c_reg_master.sv
module tb_i2c_reg_master;
    import i2cm_pkg::*;

    localparam logic [6:0] SLV = 7'h5A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic scl_oe, sda_oe;
    logic slv_drv = 1'b0, rogue = 1'b0, arm_rogue = 1'b0;
    wire scl_line = !scl_oe;
    wire sda_line = !(sda_oe || slv_drv || rogue);

    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    i2c_reg_master #(.DIV(4), .FIFO_DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_line), .scl_oe(scl_oe),
        .sda_i(sda_line), .sda_oe(sda_oe));

    // ---------------- slave model ----------------
    int s_cnt = 0, s_idx = 0, n_start = 0, n_stop = 0, nw = 0, nr = 0;
    bit s_act = 0, s_addr = 0, s_rd = 0, s_mnack = 0, s_match = 0;
    logic [7:0] s_sh = '0, addr_log = '0, s_cur;
    logic [7:0] wlog [8];
    logic mack [8];

    function automatic logic [7:0] sdat(int i);
        return {1'b1, 7'(i * 19 + 5)};
    endfunction

    always @(negedge sda_line) if (scl_line) begin
        n_start++; s_act = 1; s_addr = 1; s_cnt = -1; s_rd = 0; s_mnack = 0;
        s_idx = 0; slv_drv = 0;
        if (arm_rogue) rogue = 1;
    end

    always @(posedge sda_line) if (scl_line) begin
        n_stop++; s_act = 0; slv_drv = 0;
    end

    always @(posedge scl_line) if (s_act) begin
        if (s_cnt >= 0 && s_cnt < 8 && (s_addr || !s_rd)) s_sh = {s_sh[6:0], sda_line};
        if (s_cnt == 8 && s_rd && !s_addr) begin
            s_mnack = sda_line;
            if (nr < 8) mack[nr] = sda_line;
            nr++;
        end
    end

    always @(negedge scl_line) if (s_act) begin
        s_cnt++;
        if (s_cnt == 8) begin
            if (s_addr) begin
                addr_log = s_sh; s_match = (s_sh[7:1] == SLV); slv_drv = s_match;
            end else if (!s_rd) begin
                if (nw < 8) wlog[nw] = s_sh;
                nw++; slv_drv = 1;
            end else slv_drv = 0;
        end else if (s_cnt == 9) begin
            s_cnt = 0;
            if (s_addr) begin
                s_addr = 0; s_rd = s_sh[0];
                if (!s_match) s_act = 0;
            end else if (s_rd && s_mnack) s_act = 0;
            else if (s_rd) s_idx++;
        end
        s_cur = sdat(s_idx);
        if (s_act && s_rd && !s_addr && s_cnt < 8) slv_drv = !s_cur[7 - s_cnt];
        else if (s_cnt < 8 || !s_act) slv_drv = 0;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_wdata = v; reg_wr = 1;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); reg_addr = a; reg_rd = 1; #1 v = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic poll(input logic [7:0] mask, input string req, output logic [7:0] s);
        s = '0;
        for (int k = 0; k < 20000; k++) begin
            rd(A_STAT, s);
            if ((s & mask) != 0) break;
        end
        if ((s & mask) == 0) chk(0, req, s, mask);
    endtask

    task automatic clr_log();
        nw = 0; nr = 0; n_start = 0; n_stop = 0;
    endtask

    task automatic w_xact(input logic [6:0] a, input int n, input logic [7:0] base, output bit err);
        logic [7:0] s;
        err = 0;
        wr(A_TXD, {a, 1'b0});
        wr(A_STAT, 8'h1F);
        wr(A_CTRL, 8'h07);
        for (int i = 0; i < n; i++) begin
            poll(8'h0E, "R12", s);
            if ((s & 8'h0C) != 0) begin err = 1; break; end
            if (i == n - 1) wr(A_CTRL, 8'h05);
            wr(A_TXD, base + 8'(i));
            wr(A_STAT, 8'h02);
        end
        poll(8'h10, "R4", s);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic r_xact(input logic [6:0] a, input int n, output bit err);
        logic [7:0] s, v;
        err = 0;
        wr(A_STAT, 8'h1F);
        wr(A_THR, 8'h00);
        wr(A_TXD, {a, 1'b1});
        wr(A_CTRL, (n == 1) ? 8'h0B : 8'h03);
        for (int i = 0; i < n; i++) begin
            poll((n > 1) ? 8'h0D : 8'h09, "R6", s);
            if (s[S_RXF] == 0) begin err = 1; break; end
            if (i == n - 1) wr(A_CTRL, 8'h01);
            if (i == n - 2) wr(A_CTRL, 8'h0B);
            rd(A_RXD, v);
            chk(v == sdat(i), "R6 read byte", v, sdat(i));
            wr(A_STAT, 8'h05);
        end
        poll(8'h10, "R4", s);
        wr(A_CTRL, 8'h00);
    endtask

    // ---------------- vector table ----------------
    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [2:0] n;
        logic       exp_err;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{1'b0, 7'h5A, 3'd3, 1'b0},
        '{1'b1, 7'h5A, 3'd3, 1'b0},
        '{1'b1, 7'h5A, 3'd1, 1'b0},
        '{1'b0, 7'h5A, 3'd1, 1'b0},
        '{1'b0, 7'h21, 3'd2, 1'b1}
    };

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] s, v;
        bit err;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
        rd(A_CTRL, v); chk(v == 8'h00, "R1 ctrl", v, 8'h00);
        rd(A_STAT, v); chk(v == 8'h02, "R1 status", v, 8'h02);

        for (int t = 0; t < 5; t++) begin
            clr_log();
            if (VECS[t].rd) r_xact(VECS[t].addr, int'(VECS[t].n), err);
            else w_xact(VECS[t].addr, int'(VECS[t].n), 8'h30 + 8'(t * 16), err);
            chk(addr_log == {VECS[t].addr, VECS[t].rd}, "R2 address byte", addr_log, {VECS[t].addr, VECS[t].rd});
            chk(n_start == 1, "R3 one START", n_start, 1);
            chk(n_stop == 1, "R4 one STOP", n_stop, 1);
            chk(err == VECS[t].exp_err, "R9 tx error", err, VECS[t].exp_err);
            if (!VECS[t].rd && !VECS[t].exp_err) begin
                chk(nw == int'(VECS[t].n), "R12 byte count", nw, VECS[t].n);
                for (int i = 0; i < int'(VECS[t].n); i++)
                    chk(wlog[i] == 8'h30 + 8'(t * 16 + i), "R12 data order", wlog[i], 8'h30 + 8'(t * 16 + i));
            end
            if (VECS[t].rd) begin
                for (int i = 0; i < int'(VECS[t].n); i++)
                    chk(mack[i] == (i == int'(VECS[t].n) - 1), "R5 ack pattern", mack[i], (i == int'(VECS[t].n) - 1));
            end
        end

        // R7: threshold 1 asserts receive-full only after two bytes
        clr_log();
        wr(A_STAT, 8'h1F);
        wr(A_THR, 8'h01);
        wr(A_TXD, {SLV, 1'b1});
        wr(A_CTRL, 8'h03);
        poll(8'h01, "R7", s);
        chk(nr == 2, "R7 bytes at full", nr, 2);
        repeat (100) @(negedge clk);
        chk(nr == 2 && scl_oe, "R6 stalled", {nr[7:0], scl_oe}, {8'd2, 1'b1});
        wr(A_CTRL, 8'h01);
        rd(A_RXD, v); chk(v == sdat(0), "R7 first byte", v, sdat(0));
        rd(A_RXD, v); chk(v == sdat(1), "R7 second byte", v, sdat(1));
        poll(8'h10, "R4", s);
        chk(n_stop == 1, "R4 STOP after stall", n_stop, 1);

        // R8: write-1-to-clear and the transmit-empty rule
        wr(A_STAT, 8'h1F);
        rd(A_STAT, v); chk(v == 8'h02, "R8 clear with empty FIFO", v, 8'h02);
        wr(A_TXD, 8'hAA);
        wr(A_STAT, 8'h02);
        rd(A_STAT, v); chk(v == 8'h00, "R8 clear with data", v, 8'h00);

        // R11: disable flushes the FIFO; no START without a new address
        wr(A_CTRL, 8'h00);
        rd(A_STAT, v); chk(v[S_TXE] == 1'b1, "R11 flushed", v, 8'h02);
        clr_log();
        wr(A_CTRL, 8'h03);
        repeat (200) @(negedge clk);
        chk(n_start == 0 && !scl_oe && !sda_oe, "R11 no START", n_start, 0);
        wr(A_CTRL, 8'h00);

        // R10: arbitration loss
        clr_log();
        arm_rogue = 1;
        wr(A_STAT, 8'h1F);
        wr(A_TXD, {SLV, 1'b0});
        wr(A_CTRL, 8'h07);
        poll(8'h08, "R10", s);
        arm_rogue = 0;
        rd(A_CTRL, v); chk(v[C_MS] == 1'b0, "R10 master cleared", v, 8'h05);
        chk(!scl_oe && !sda_oe, "R10 released", {scl_oe, sda_oe}, 0);
        rogue = 0;
        wr(A_CTRL, 8'h00);
        repeat (20) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule